// File: doc/BRIEF.md
# Precision-Scalable Signed Array Multiplier

This block multiplies two two's-complement operands in a single combinational array. It uses the Baugh-Wooley partial-product arrangement, so signed operands need no sign-extension rows. A mode input selects between a full 16-bit multiply and an 8-bit multiply.

In 8-bit mode the two narrow operands are placed on the upper byte of each operand input. The lower input bits are forced to zero before they enter the array, so the adders fed by them stop toggling. The narrow product is then formed by the quadrant of the array that the operand MSBs drive. In this arrangement the correction constants and inverted terms of the wide array reduce to the correction constants of an 8-bit Baugh-Wooley multiply. No operand is ever sign-extended into the unused rows.

The block sits inside a larger arithmetic datapath. That datapath can drop to low precision whenever switching energy matters more than accuracy.

Top module: `bwm_top`

## Requirements
- R1: With `half_mode`=0, `product` equals the exact 32-bit two's-complement product of `op_a` and `op_b` (both signed 16-bit) for every input pair.
- R2: With `half_mode`=0, the most-negative operand cases are exact: -32768 × -32768 gives 0x40000000, and -32768 × 32767 gives 0xC0008000.
- R3: With `half_mode`=1, the signed 8-bit operands are `op_a[15:8]` and `op_b[15:8]`, and `product[31:16]` equals their exact signed 16-bit product.
- R4: With `half_mode`=1, `product[15:0]` is 0.
- R5: With `half_mode`=1, `op_a[7:0]` and `op_b[7:0]` have no effect on `product`, because they are forced to 0 before the array.
- R6: `half_mode` alone selects the precision: the same operand pair gives the R1 result when it is 0 and the R3/R4 result when it is 1.
- R7: With `half_mode`=1, the 8-bit corner -128 × -128 gives 16384 in `product[31:16]`, and -128 × 127 gives -16256 there.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| op_a | input | 16 | Multiplicand, two's complement (8-bit operand in bits [15:8] when half_mode=1) |
| op_b | input | 16 | Multiplier, two's complement (8-bit operand in bits [15:8] when half_mode=1) |
| half_mode | input | 1 | 1 selects 8-bit precision, 0 selects 16-bit precision |
| product | output | 32 | Signed product (8-bit result in bits [31:16] when half_mode=1) |

## Verification
Directed sign combinations (positive by positive, negative by positive, negative by negative, and zero) show whether the inverted sign-row terms and the two correction ones are placed correctly. The most-negative values in both precisions expose any carry lost out of the top bit. Randomly chosen pairs in each mode cover carry propagation across the whole array. In 8-bit mode, pairs that differ only in their low bytes are applied back to back, so a gate leak shows up as a changed product. The same operand pair is also applied in both modes, to tell a wrong mode decode apart from an arithmetic fault.

// File: rtl/bwm_pkg.sv
package bwm_pkg;

  // One partial-product bit of a Baugh-Wooley array of width w:
  // a term that involves exactly one sign bit is inverted.
  function automatic logic bw_term(input logic a_i, input logic b_j,
                                   input int i, input int j, input int w);
    logic raw;
    logic one_sign;
    raw      = a_i & b_j;
    one_sign = (i == w - 1) ^ (j == w - 1);
    return one_sign ? ~raw : raw;
  endfunction

  // Position of the two correction ones for a w-bit multiply.
  function automatic int corr_lo(input int w);
    return w;
  endfunction

  function automatic int corr_hi(input int w);
    return 2 * w - 1;
  endfunction

endpackage

// File: rtl/bwm_operand_gate.sv
module bwm_operand_gate #(
  parameter int W   = 16,
  parameter int LOW = 8
) (
  input  logic [W-1:0] din,
  input  logic         gate,
  output logic [W-1:0] dout
);
  for (genvar i = 0; i < W; i++) begin : g_bit
    if (i < LOW) begin : g_gated
      assign dout[i] = din[i] & ~gate;
    end else begin : g_pass
      assign dout[i] = din[i];
    end
  end
endmodule

// File: rtl/bwm_pp_array.sv
module bwm_pp_array
  import bwm_pkg::*;
#(
  parameter int W = 16
) (
  input  logic [W-1:0]            a,
  input  logic [W-1:0]            b,
  output logic [W-1:0][2*W-1:0]   rows
);
  localparam int PW = 2 * W;

  logic [W-1:0][W-1:0] terms;

  for (genvar i = 0; i < W; i++) begin : g_row
    for (genvar j = 0; j < W; j++) begin : g_col
      assign terms[j][i] = bw_term(a[i], b[j], i, j, W);
    end
  end

  // Row j holds the terms with b[j], shifted to weight j.
  always_comb begin
    for (int j = 0; j < W; j++) begin
      rows[j] = PW'(terms[j]) << j;
    end
  end
endmodule

// File: rtl/bwm_row_sum.sv
module bwm_row_sum
  import bwm_pkg::*;
#(
  parameter int W = 16
) (
  input  logic [W-1:0][2*W-1:0] rows,
  output logic [2*W-1:0]        sum
);
  localparam int PW = 2 * W;

  logic [PW-1:0] corr;

  always_comb begin
    corr = '0;
    corr[corr_lo(W)] = 1'b1;
    corr[corr_hi(W)] = 1'b1;
  end

  always_comb begin
    sum = corr;
    for (int j = 0; j < W; j++) begin
      sum = sum + rows[j];
    end
  end
endmodule

// File: rtl/bwm_top.sv
module bwm_top #(
  parameter int W = 16
) (
  input  logic [W-1:0]   op_a,
  input  logic [W-1:0]   op_b,
  input  logic           half_mode,
  output logic [2*W-1:0] product
);
  localparam int HALF = W / 2;
  localparam int PW   = 2 * W;

  logic [W-1:0]          gated_a;
  logic [W-1:0]          gated_b;
  logic [W-1:0][PW-1:0]  pp_rows;
  logic [PW-1:0]         array_sum;

  bwm_operand_gate #(.W(W), .LOW(HALF)) u_gate_a (
    .din (op_a), .gate(half_mode), .dout(gated_a)
  );

  bwm_operand_gate #(.W(W), .LOW(HALF)) u_gate_b (
    .din (op_b), .gate(half_mode), .dout(gated_b)
  );

  bwm_pp_array #(.W(W)) u_array (
    .a(gated_a), .b(gated_b), .rows(pp_rows)
  );

  bwm_row_sum #(.W(W)) u_sum (
    .rows(pp_rows), .sum(array_sum)
  );

  assign product = array_sum;
endmodule

// File: rtl/bwm_chk.sv
module bwm_chk #(
  parameter int W = 16
) (
  input logic [W-1:0]   op_a,
  input logic [W-1:0]   op_b,
  input logic           half_mode,
  input logic [W-1:0]   gated_a,
  input logic [W-1:0]   gated_b,
  input logic [2*W-1:0] product
);
  localparam int HALF = W / 2;
  localparam int PW   = 2 * W;

  logic signed [PW-1:0] wide_a, wide_b, wide_ref;
  logic signed [W-1:0]  nar_a, nar_b, nar_ref;
  logic                 known;

  always_comb begin
    wide_a   = $signed({{W{op_a[W-1]}}, op_a});
    wide_b   = $signed({{W{op_b[W-1]}}, op_b});
    wide_ref = wide_a * wide_b;
    nar_a    = $signed({{HALF{op_a[W-1]}}, op_a[W-1:HALF]});
    nar_b    = $signed({{HALF{op_b[W-1]}}, op_b[W-1:HALF]});
    nar_ref  = nar_a * nar_b;
    known    = !$isunknown({op_a, op_b, half_mode});
  end

  always_comb begin
    if (known) begin
      // R1
      full_prod_chk: assert (half_mode || product == wide_ref)
        else $error("full-width product mismatch");
      // R3
      half_prod_chk: assert (!half_mode || product[PW-1:W] == nar_ref)
        else $error("narrow product mismatch");
      // R4
      half_low_zero_chk: assert (!half_mode || product[W-1:0] == '0)
        else $error("narrow mode low half not zero");
      // R5
      gate_low_chk: assert (!half_mode ||
                            (gated_a[HALF-1:0] == '0 && gated_b[HALF-1:0] == '0))
        else $error("low operand bits not gated");
      // R6
      gate_pass_chk: assert (half_mode || (gated_a == op_a && gated_b == op_b))
        else $error("operands altered in full mode");
    end
  end
endmodule

bind bwm_top bwm_chk #(.W(W)) u_chk (
  .op_a(op_a), .op_b(op_b), .half_mode(half_mode),
  .gated_a(gated_a), .gated_b(gated_b), .product(product)
);

// File: tb/sim_bwm_top.sv
module sim_bwm_top;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [15:0] op_a = '0;
  logic [15:0] op_b = '0;
  logic        half_mode = 1'b0;
  logic [31:0] product;

  int checks = 0;
  int errors = 0;
  int cycles = 0;
  logic done = 1'b0;

  logic [31:0] exp_q[$];
  string       tag_q[$];

  always #4 clk = ~clk;

  bwm_top u0 (.op_a(op_a), .op_b(op_b), .half_mode(half_mode), .product(product));

  // Reference model, written from the requirements.
  function automatic logic [31:0] model(input logic m, input logic [15:0] a,
                                        input logic [15:0] b);
    longint pa, pb, pr;
    if (!m) begin
      pa = longint'($signed(a));
      pb = longint'($signed(b));
      pr = pa * pb;
      return pr[31:0];
    end else begin
      pa = longint'($signed(a[15:8]));
      pb = longint'($signed(b[15:8]));
      pr = pa * pb;
      return {pr[15:0], 16'h0000};
    end
  endfunction

  task automatic drive(input logic m, input logic [15:0] a, input logic [15:0] b,
                       input string tag);
    @(posedge clk);
    #1;
    half_mode = m;
    op_a = a;
    op_b = b;
    exp_q.push_back(model(m, a, b));
    tag_q.push_back(tag);
  endtask

  task automatic drive_exp(input logic m, input logic [15:0] a, input logic [15:0] b,
                           input logic [31:0] e, input string tag);
    @(posedge clk);
    #1;
    half_mode = m;
    op_a = a;
    op_b = b;
    exp_q.push_back(e);
    tag_q.push_back(tag);
  endtask

  // Monitor: compares on the falling edge, half a cycle after each drive.
  always @(negedge clk) begin
    if (rst_n && exp_q.size() > 0) begin
      logic [31:0] e;
      string t;
      e = exp_q.pop_front();
      t = tag_q.pop_front();
      checks++;
      if (product !== e) begin
        errors++;
        $display("FAIL %s: product=%h expected=%h (a=%h b=%h half=%b)",
                 t, product, e, op_a, op_b, half_mode);
      end
    end
  end

  always @(posedge clk) begin
    cycles++;
    if (cycles > 20000 && !done) begin
      done = 1'b1;
      errors++;
      $display("FAIL watchdog: cycles=%0d expected=<20000", cycles);
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (3) @(posedge clk);
    rst_n = 1'b1;
    // Idle state after reset: zero operands give zero.
    drive_exp(1'b0, 16'h0000, 16'h0000, 32'h0000_0000, "R1 reset zero");

    // R1 sign patterns
    drive(1'b0, 16'd300,  16'd200,  "R1 pos*pos");
    drive(1'b0, 16'hFFFF, 16'd5,    "R1 neg*pos");
    drive(1'b0, 16'd7,    16'hFFF0, "R1 pos*neg");
    drive(1'b0, 16'hFF00, 16'hFE00, "R1 neg*neg");
    drive(1'b0, 16'h7FFF, 16'h7FFF, "R1 max*max");

    // R2 most-negative corners
    drive_exp(1'b0, 16'h8000, 16'h8000, 32'h4000_0000, "R2 min*min");
    drive_exp(1'b0, 16'h8000, 16'h7FFF, 32'hC000_8000, "R2 min*max");

    // R3 narrow products
    drive(1'b1, 16'h0500, 16'h0300, "R3 pos*pos");
    drive(1'b1, 16'hFD00, 16'h0900, "R3 neg*pos");
    drive(1'b1, 16'hF000, 16'hF100, "R3 neg*neg");

    // R7 narrow corners
    drive_exp(1'b1, 16'h8000, 16'h8000, 32'h4000_0000, "R7 -128*-128");
    drive_exp(1'b1, 16'h8000, 16'h7F00, 32'hC080_0000, "R7 -128*127");

    // R4 / R5: low bytes toggled, narrow result unchanged and low half zero
    drive_exp(1'b1, 16'h1200, 16'h3400, 32'h03A8_0000, "R5 low bytes zero");
    drive_exp(1'b1, 16'h12FF, 16'h34FF, 32'h03A8_0000, "R5 low bytes ones");
    drive_exp(1'b1, 16'h12A5, 16'h345A, 32'h03A8_0000, "R4 low half zero");

    // R6 same pair in both modes
    drive(1'b0, 16'hC3A5, 16'h1E77, "R6 full mode");
    drive(1'b1, 16'hC3A5, 16'h1E77, "R6 half mode");

    for (int k = 0; k < 300; k++) begin
      logic [15:0] ra, rb;
      ra = 16'($urandom);
      rb = 16'($urandom);
      drive(1'b0, ra, rb, "R1 random");
      drive(1'b1, ra, rb, "R3 random");
    end

    @(posedge clk);
    @(posedge clk);
    if (!done) begin
      done = 1'b1;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end
endmodule